// File: doc/BRIEF.md
# Boot Source Fallback Sequencer

This block brings a chip up from reset by loading the first-stage boot image into on-chip RAM. It first reads the wake cause. On a return from deep sleep it skips the load and raises a resume indication. On any other wake it issues a one-cycle watchdog-disable pulse, then a one-cycle clock-setup pulse. After that it asks a loader engine for the image. The first engine tried is the device chosen by the mode straps. If that attempt fails, the block falls back to the second SD channel, then the serial port, then USB.

Each engine is abstracted as a request line plus a word stream with valid and error inputs. The sequencer writes every word it accepts into RAM, starting at a fixed byte offset. It adds up all words except the last one, and the last word carries the expected sum. An attempt fails on an error, on a timeout, or on a checksum mismatch. A failed attempt moves the sequencer to the next source in the chain. When an attempt succeeds, the block reports which chain stage delivered the image. When every stage fails, it stops in a terminal failed state. All status outputs stay fixed until the next reset.

The image size, RAM size, landing offset, word width, strap width and timeout length are all parameters. The defaults are a 16 KB image, 96 KB of RAM and 32-bit words.

Top module: `boot_chain_seq`

## Requirements
- R1: While rst_n is low, boot_done, boot_fail, resume, wdt_off, clk_cfg, ram_we and ld_req are all 0.
- R2: After reset release with wake_deep low, the outputs follow a fixed cycle order. wdt_off is high for exactly one cycle, starting one cycle after release. clk_cfg is high for exactly one cycle, in the cycle after that. ld_req bit 0 rises in the next cycle.
- R3: If wake_deep is high at reset release, resume rises one cycle later and stays high. No pulse is issued and no ld_req bit is ever raised.
- R4: While an attempt is active, every word presented with ld_valid is written out in the same cycle. ram_we is high, ram_wdata equals ld_data, and ram_addr equals RAM_OFF + 4 × (the word's index within the attempt).
- R5: An attempt succeeds when the 32-bit wrapping sum of words 0 to N-2 equals word N-1, where N is the image size in words. boot_done then rises two cycles after the last word is written, and boot_src shows the stage code.
- R6: A checksum mismatch fails the attempt, and the request moves to the next stage.
- R7: ld_err during an attempt abandons it, and the next stage's request appears one cycle later.
- R8: An attempt that has not finished within TMO_CYCLES cycles fails, and the request moves to the next stage.
- R9: The stages are tried in a fixed order: code 0 is the strap-selected device, 1 is SD channel 2, 2 is UART and 3 is USB. Stage k drives ld_req bit k, and at most one bit is high at a time. During stage 0, ld_dev equals strap_sel.
- R10: If stage 3 fails, boot_fail goes high and stays high, and boot_done stays low.
- R11: Once boot_done is high, boot_done and boot_src do not change until reset.

Of these, R2, R3, R4, R7, R9, R10 and R11 are also expressed as assertions inside the RTL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap_sel | input | STRAP_W | Mode straps that select the primary device |
| wake_deep | input | 1 | Wake cause is a return from deep sleep |
| wdt_off | output | 1 | One-cycle watchdog-disable pulse |
| clk_cfg | output | 1 | One-cycle clock-setup pulse |
| ld_req | output | 4 | One-hot loader request, bit k for stage k |
| ld_dev | output | STRAP_W | Device code for the primary-stage engine |
| ld_valid | input | 1 | The engine presents a word |
| ld_data | input | DATA_W | Image word |
| ld_err | input | 1 | The engine reports an error |
| ram_we | output | 1 | On-chip RAM write enable |
| ram_addr | output | ADDR_W | RAM byte address |
| ram_wdata | output | DATA_W | RAM write data |
| boot_done | output | 1 | Image loaded and checked |
| boot_fail | output | 1 | Every stage failed |
| boot_src | output | 2 | Stage code of the successful source |
| resume | output | 1 | Deep-sleep resume path taken |

## Verification
The results of this block are due at fixed cycle offsets.

- The watchdog pulse comes one cycle after reset release, the clock pulse one cycle later, and the first request one cycle after that.
- A RAM write is combinational with the accepted word.
- A retry request appears one cycle after an error or timeout. After a checksum mismatch it appears two cycles after the last word.
- boot_done comes exactly two cycles after the last write.

The bench samples every output a fixed delay after the falling edge, and it counts cycles on that sample. The scoreboard compares the expected stage order, write addresses and data, and the pulse cycles against these offsets. Final states are sampled again several cycles later to confirm they hold.

// File: rtl/boot_chain_pkg.sv
package boot_chain_pkg;
   typedef enum logic [2:0] {
      ST_START, ST_WDT, ST_CLK, ST_LOAD, ST_CHECK, ST_DONE, ST_FAIL, ST_RESUME
   } bc_state_e;

   localparam int unsigned N_STAGES = 4;
   typedef logic [1:0] stage_t;
   localparam stage_t STG_PRIMARY = 2'd0;
   localparam stage_t STG_SD2     = 2'd1;
   localparam stage_t STG_UART    = 2'd2;
   localparam stage_t STG_USB     = 2'd3;
endpackage

// File: rtl/boot_chain_sum.sv
module boot_chain_sum #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              take,
   input  logic              last,
   input  logic [DATA_W-1:0] word,
   output logic              match
);
   logic [DATA_W-1:0] sum_q;
   logic [DATA_W-1:0] ref_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
         ref_q <= '0;
      end else if (clr) begin
         sum_q <= '0;
         ref_q <= '0;
      end else if (take) begin
         if (last) ref_q <= word;
         else      sum_q <= sum_q + word;
      end
   end

   assign match = (sum_q == ref_q);
endmodule

// File: rtl/boot_chain_tmo.sv
module boot_chain_tmo #(
   parameter int unsigned LIMIT = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic hit
);
   localparam int unsigned CNT_W = $clog2(LIMIT + 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("boot_chain_tmo: LIMIT must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   assign hit = run && (cnt_q == CNT_W'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (clr)           cnt_q <= '0;
      else if (run && !hit)   cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/boot_chain_seq.sv
module boot_chain_seq
   import boot_chain_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned STRAP_W    = 2,
   parameter int unsigned IMG_BYTES  = 16384,
   parameter int unsigned RAM_BYTES  = 98304,
   parameter int unsigned RAM_OFF    = 0,
   parameter int unsigned TMO_CYCLES = 100000,
   localparam int unsigned BYTES_W   = DATA_W / 8,
   localparam int unsigned IMG_WORDS = IMG_BYTES / BYTES_W,
   localparam int unsigned CNT_W     = $clog2(IMG_WORDS),
   localparam int unsigned ADDR_W    = $clog2(RAM_BYTES),
   localparam int unsigned SHIFT     = $clog2(BYTES_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] strap_sel,
   input  logic               wake_deep,
   output logic               wdt_off,
   output logic               clk_cfg,
   output logic [3:0]         ld_req,
   output logic [STRAP_W-1:0] ld_dev,
   input  logic               ld_valid,
   input  logic [DATA_W-1:0]  ld_data,
   input  logic               ld_err,
   output logic               ram_we,
   output logic [ADDR_W-1:0]  ram_addr,
   output logic [DATA_W-1:0]  ram_wdata,
   output logic               boot_done,
   output logic               boot_fail,
   output logic [1:0]         boot_src,
   output logic               resume
);
   if (DATA_W % 8 != 0 || IMG_BYTES % BYTES_W != 0) begin : g_bad_width
      $error("boot_chain_seq: image must be whole words of whole bytes");
   end
   if (IMG_WORDS < 2) begin : g_bad_img
      $error("boot_chain_seq: image needs at least two words");
   end
   if (RAM_OFF + IMG_BYTES > RAM_BYTES) begin : g_bad_ram
      $error("boot_chain_seq: image does not fit in RAM");
   end

   bc_state_e         state_q, state_d;
   stage_t            stage_q;
   logic [CNT_W-1:0]  widx_q;
   logic [STRAP_W-1:0] strap_q;
   logic              take, last_word, sum_ok, tmo_hit, fail_now, att_clr;
   logic              in_load, last_stage;

   assign in_load    = (state_q == ST_LOAD);
   assign last_stage = (stage_q == STG_USB);
   assign take       = in_load && ld_valid && !ld_err;
   assign last_word  = (widx_q == CNT_W'(IMG_WORDS - 1));
   assign fail_now   = (in_load && (ld_err || (!take && tmo_hit)))
                    || (state_q == ST_CHECK && !sum_ok);
   assign att_clr    = (state_q == ST_CLK) || fail_now;

   boot_chain_sum #(.DATA_W(DATA_W)) u_sum (
      .clk(clk), .rst_n(rst_n), .clr(att_clr), .take(take),
      .last(last_word), .word(ld_data), .match(sum_ok)
   );

   boot_chain_tmo #(.LIMIT(TMO_CYCLES)) u_tmo (
      .clk(clk), .rst_n(rst_n), .clr(att_clr), .run(in_load), .hit(tmo_hit)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_START: state_d = wake_deep ? ST_RESUME : ST_WDT;
         ST_WDT:   state_d = ST_CLK;
         ST_CLK:   state_d = ST_LOAD;
         ST_LOAD: begin
            if (fail_now)                state_d = last_stage ? ST_FAIL : ST_LOAD;
            else if (take && last_word)  state_d = ST_CHECK;
         end
         ST_CHECK: begin
            if (sum_ok)                  state_d = ST_DONE;
            else                         state_d = last_stage ? ST_FAIL : ST_LOAD;
         end
         default:  state_d = state_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_START;
         stage_q <= STG_PRIMARY;
         widx_q  <= '0;
         strap_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_START) strap_q <= strap_sel;
         if (fail_now && !last_stage) stage_q <= stage_q + 1'b1;
         if (att_clr)     widx_q <= '0;
         else if (take)   widx_q <= widx_q + 1'b1;
      end
   end

   for (genvar g = 0; g < N_STAGES; g++) begin : g_req
      assign ld_req[g] = in_load && (stage_q == stage_t'(g));
   end

   assign ld_dev    = (in_load && stage_q == STG_PRIMARY) ? strap_q : '0;
   assign wdt_off   = (state_q == ST_WDT);
   assign clk_cfg   = (state_q == ST_CLK);
   assign ram_we    = take;
   assign ram_wdata = ld_data;
   assign ram_addr  = ADDR_W'(RAM_OFF) + (ADDR_W'(widx_q) << SHIFT);
   assign boot_done = (state_q == ST_DONE);
   assign boot_fail = (state_q == ST_FAIL);
   assign resume    = (state_q == ST_RESUME);
   assign boot_src  = stage_q;

   assert_req_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ld_req));
   assert_pulse_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_off |=> clk_cfg && !wdt_off);
   assert_cfg_then_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clk_cfg |=> ld_req[0] && !clk_cfg);
   assert_resume_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      resume |-> (ld_req == 4'b0) && !wdt_off && !clk_cfg && !ram_we);
   assert_write_in_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (ld_req != 4'b0));
   assert_err_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_req[0] && ld_err) |=> ld_req[1]);
   assert_fail_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      boot_fail |=> boot_fail && !boot_done);
   assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done |=> boot_done && $stable(boot_src));
endmodule

// File: tb/boot_chain_seq_tb.sv
module boot_chain_seq_tb;
   localparam int unsigned IMGB = 32;
   localparam int unsigned WORDS = 8;
   localparam int unsigned RAMB = 256;
   localparam int unsigned ROFF = 64;
   localparam int unsigned TMO = 40;
   localparam int unsigned WD_LIMIT = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] strap_sel = '0;
   logic wake_deep = 1'b0;
   logic wdt_off, clk_cfg, ram_we, boot_done, boot_fail, resume;
   logic [3:0] ld_req;
   logic [1:0] ld_dev, boot_src;
   logic ld_valid = 1'b0, ld_err = 1'b0;
   logic [31:0] ld_data = '0, ram_wdata;
   logic [7:0] ram_addr;

   always #5 clk = ~clk;

   boot_chain_seq #(.DATA_W(32), .STRAP_W(2), .IMG_BYTES(IMGB), .RAM_BYTES(RAMB),
                    .RAM_OFF(ROFF), .TMO_CYCLES(TMO)) u_dut (
      .clk(clk), .rst_n(rst_n), .strap_sel(strap_sel), .wake_deep(wake_deep),
      .wdt_off(wdt_off), .clk_cfg(clk_cfg), .ld_req(ld_req), .ld_dev(ld_dev),
      .ld_valid(ld_valid), .ld_data(ld_data), .ld_err(ld_err),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .boot_done(boot_done), .boot_fail(boot_fail), .boot_src(boot_src),
      .resume(resume));

   int total = 0, bad = 0, cyc = 0;
   int beh [4];            // 0 good, 1 bad sum, 2 error, 3 silent
   int stage_q [$];
   int addr_q [$];
   logic [31:0] data_q [$];
   int wdt_cyc, cfg_cyc, req_cyc, wdt_cnt, cfg_cnt, last_we_cyc;
   logic [3:0] eng_prev = '0, mon_prev = '0;
   int eng_k = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] img_word(int s, int k, int b);
      logic [31:0] acc = '0;
      if (k < WORDS - 1) return 32'hF000_0000 + 32'h1357_9BDF * k + s;
      for (int i = 0; i < WORDS - 1; i++) acc += 32'hF000_0000 + 32'h1357_9BDF * i + s;
      return acc + ((b == 1) ? 32'd1 : 32'd0);
   endfunction

   function automatic int req_idx(logic [3:0] r);
      for (int i = 0; i < 4; i++) if (r[i]) return i;
      return -1;
   endfunction

   // engine model (driver side of the scoreboard)
   always @(negedge clk) begin
      logic [3:0] cur;
      cur = ld_req;
      if (cur != eng_prev) eng_k = 0;
      eng_prev = cur;
      ld_valid = 1'b0; ld_err = 1'b0; ld_data = '0;
      if (cur != 4'b0) begin
         int s, b;
         s = req_idx(cur); b = beh[s];
         if (b == 2 && eng_k == 3) ld_err = 1'b1;
         else if (b != 3 && eng_k < WORDS) begin
            ld_valid = 1'b1;
            ld_data = img_word(s, eng_k, b);
            addr_q.push_back(ROFF + 4 * eng_k);
            data_q.push_back(ld_data);
            eng_k++;
         end
      end
   end

   // monitor
   always @(negedge clk) begin
      #2;
      cyc++;
      if (rst_n) begin
         if (wdt_off) begin wdt_cnt++; wdt_cyc = cyc; end
         if (clk_cfg) begin cfg_cnt++; cfg_cyc = cyc; end
         if (ld_req != 4'b0 && ld_req != mon_prev) begin
            int s;
            s = req_idx(ld_req);
            if (req_cyc < 0) req_cyc = cyc;
            if (stage_q.size() == 0) chk(0, "R9", "unexpected attempt", s, -1);
            else begin
               int e;
               e = stage_q.pop_front();
               chk(s == e, "R9", "stage order", s, e);
            end
            if (s == 0) chk(ld_dev == strap_sel, "R9", "ld_dev", ld_dev, strap_sel);
         end
         if (ram_we) begin
            last_we_cyc = cyc;
            if (addr_q.size() == 0) chk(0, "R4", "unexpected write", ram_addr, -1);
            else begin
               int ea;
               logic [31:0] ed;
               ea = addr_q.pop_front(); ed = data_q.pop_front();
               chk(ram_addr == ea, "R4", "ram_addr", ram_addr, ea);
               chk(ram_wdata == ed, "R4", "ram_wdata", ram_wdata, ed);
            end
         end
      end
      mon_prev = ld_req;
   end

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(negedge clk) if (cyc > WD_LIMIT) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cyc, WD_LIMIT);
      summary();
   end

   // kind: 0 done, 1 fail, 2 resume
   task automatic run_case(input logic [1:0] strap, input bit wake,
                           input int b0, input int b1, input int b2, input int b3,
                           input int kind, input int src, input int nstages);
      int w;
      beh[0] = b0; beh[1] = b1; beh[2] = b2; beh[3] = b3;
      rst_n = 1'b0; strap_sel = strap; wake_deep = wake;
      stage_q.delete(); addr_q.delete(); data_q.delete();
      for (int i = 0; i < nstages; i++) stage_q.push_back(i);
      repeat (3) @(negedge clk);
      #2;
      chk({boot_done, boot_fail, resume, wdt_off, clk_cfg, ram_we, ld_req} == '0,
          "R1", "reset outputs", {boot_done, boot_fail, resume, wdt_off, clk_cfg, ram_we, ld_req}, 0);
      wdt_cnt = 0; cfg_cnt = 0; wdt_cyc = -1; cfg_cyc = -1; req_cyc = -1; last_we_cyc = -100;
      @(negedge clk); rst_n = 1'b1;
      w = 0;
      do begin @(negedge clk); #3; w++; end
      while (!(boot_done || boot_fail || resume) && w < 2000);
      if (kind == 2) begin
         chk(resume, "R3", "resume", resume, 1);
         chk(wdt_cnt == 0 && cfg_cnt == 0 && req_cyc < 0, "R3", "no pulses or requests",
             wdt_cnt + cfg_cnt, 0);
         chk(w == 1, "R3", "resume latency", w, 1);
      end else begin
         chk(wdt_cnt == 1 && cfg_cnt == 1, "R2", "pulse counts", wdt_cnt * 16 + cfg_cnt, 17);
         chk(cfg_cyc == wdt_cyc + 1 && req_cyc == cfg_cyc + 1, "R2", "pulse order",
             req_cyc - wdt_cyc, 2);
         if (kind == 0) begin
            chk(boot_done && !boot_fail, "R5", "boot_done", boot_done, 1);
            chk(boot_src == src, "R5", "boot_src", boot_src, src);
            chk(cyc - last_we_cyc == 2, "R5", "done latency", cyc - last_we_cyc, 2);
         end else begin
            chk(boot_fail && !boot_done, "R10", "boot_fail", boot_fail, 1);
         end
         chk(stage_q.size() == 0, "R9", "stages left untried", stage_q.size(), 0);
      end
      repeat (6) @(negedge clk);
      #3;
      if (kind == 0)
         chk(boot_done && boot_src == src, "R11", "done held", {boot_done, boot_src}, {1'b1, 2'(src)});
      else if (kind == 1)
         chk(boot_fail && !boot_done, "R10", "fail held", boot_fail, 1);
      else
         chk(resume && ld_req == 0, "R3", "resume held", resume, 1);
   endtask

   initial begin
      beh[0] = 0; beh[1] = 0; beh[2] = 0; beh[3] = 0;
      run_case(2'd2, 0, 0, 0, 0, 0, 0, 0, 1);   // R5 primary good
      run_case(2'd1, 0, 1, 0, 0, 0, 0, 1, 2);   // R6 mismatch -> SD2
      run_case(2'd3, 0, 2, 2, 0, 0, 0, 2, 3);   // R7 errors -> UART
      run_case(2'd0, 0, 3, 1, 2, 0, 0, 3, 4);   // R8 timeout, full chain -> USB
      run_case(2'd2, 0, 1, 3, 2, 1, 1, 0, 4);   // R10 total failure
      run_case(2'd1, 1, 0, 0, 0, 0, 2, 0, 0);   // R3 deep-sleep resume
      run_case(2'd0, 0, 0, 0, 0, 0, 0, 0, 1);   // R1 recovery after resume
      summary();
   end
endmodule